// File: doc/BRIEF.md
# Ordered Dithering Pixel Thresholder

This block turns a stream of 8-bit grayscale pixels into a two-level halftone stream. Each pixel is compared with a threshold picked from a small periodic matrix. The matrix is indexed by the pixel's column position modulo four and by the parity of its row. A pixel strictly above its threshold leaves as full white (255). Any other pixel leaves as black (0).

Pixels enter on a valid/ready channel that carries a start-of-line and a start-of-frame marker with each pixel. Results leave on a second valid/ready channel after one register stage, in the order they were accepted. The threshold values are fixed when the block is built. The block accepts a new pixel in every cycle in which the output side is free or being drained.

Top module: `dither_thresholder`

## Requirements
- R1: On an even row, the thresholds for column phases 0, 1, 2 and 3 are 32, 160, 224 and 96.
- R2: On an odd row, the thresholds for column phases 0, 1, 2 and 3 are 224, 96, 32 and 160.
- R3: The decision is an unsigned strict greater-than. A pixel above its threshold gives 255; a pixel equal to or below it gives 0. No other output value ever appears.
- R4: Each accepted pixel without markers advances the column phase by one, and the phase wraps from 3 to 0. A pixel with the start-of-line marker takes column phase 0.
- R5: A pixel with the start-of-frame marker takes row parity even and column phase 0. A pixel with start-of-line but without start-of-frame flips the row parity relative to the previous line.
- R6: After reset the output channel is empty, and the first pixel accepted without markers uses even row, column phase 0.
- R7: An accepted pixel appears on the output in the next cycle. When out_ready is high, in_ready is high, so one pixel can be accepted every cycle.
- R8: While out_valid is high and out_ready is low, the output pixel holds its value and no input is taken. Every accepted pixel leaves exactly once, in order.
- R9: Markers presented while in_valid is low have no effect on column phase or row parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take the input pixel this cycle |
| in_pixel | input | 8 | Grayscale input value |
| in_sol | input | 1 | Pixel is the first of a line |
| in_sof | input | 1 | Pixel is the first of a frame |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Receiver takes the output pixel this cycle |
| out_pixel | output | 8 | Halftone result, 0 or 255 |

## Verification
The two functions that share a cycle are taking a new pixel and releasing the registered result under a changing out_ready. When out_ready returns high while a result is waiting, the stored result must leave in the same cycle that the next pixel is taken. The random phase toggles out_ready and in_valid on most cycles to force this overlap often. Line and frame markers arrive at random column phases, including on stalled cycles. Each released pixel is compared in order against a queue of values that a bench model computes, and every stalled cycle is checked to hold the previous output unchanged.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int unsigned COL_W = 2;
  localparam int unsigned PHASES = 1 << COL_W;

  // Pattern slot used by a pixel: odd rows start half a period later.
  function automatic logic [COL_W-1:0] pattern_slot(input logic row_odd,
                                                   input logic [COL_W-1:0] col);
    return col ^ {row_odd, {(COL_W-1){1'b0}}};
  endfunction

  // Threshold of a slot expressed in eighths of full scale.
  function automatic int unsigned slot_eighths(input logic [COL_W-1:0] slot);
    case (slot)
      2'd0:    return 1;
      2'd1:    return 5;
      2'd2:    return 7;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/dith_position.sv
module dith_position
  import dith_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sol,
  input  logic             sof,
  output logic             pos_row,
  output logic [COL_W-1:0] pos_col
);
  logic             row_q;
  logic [COL_W-1:0] next_col_q;

  always_comb begin
    if (sof) begin
      pos_row = 1'b0;
      pos_col = '0;
    end else if (sol) begin
      pos_row = ~row_q;
      pos_col = '0;
    end else begin
      pos_row = row_q;
      pos_col = next_col_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q      <= 1'b0;
      next_col_q <= '0;
    end else if (accept) begin
      row_q      <= pos_row;
      next_col_q <= pos_col + 1'b1;
    end
  end
endmodule

// File: rtl/dith_compare.sv
module dith_compare
  import dith_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] pixel,
  input  logic             row_odd,
  input  logic [COL_W-1:0] col,
  output logic [PIX_W-1:0] threshold,
  output logic [PIX_W-1:0] result
);
  localparam int unsigned SHIFT = PIX_W - 3;

  always_comb begin
    threshold = PIX_W'(slot_eighths(pattern_slot(row_odd, col))) << SHIFT;
    result    = (pixel > threshold) ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
  end
endmodule

// File: rtl/dith_outstage.sv
module dith_outstage #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PIX_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PIX_W-1:0] dn_data
);
  logic             full_q;
  logic [PIX_W-1:0] data_q;

  assign up_ready = ~full_q | dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/dither_thresholder.sv
module dither_thresholder
  import dith_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_sol,
  input  logic             in_sof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel
);
  logic             accept;
  logic             pos_row;
  logic [COL_W-1:0] pos_col;
  logic [PIX_W-1:0] cur_threshold;
  logic [PIX_W-1:0] bin_pixel;

  assign accept = in_valid & in_ready;

  dith_position u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .sol     (in_sol),
    .sof     (in_sof),
    .pos_row (pos_row),
    .pos_col (pos_col)
  );

  dith_compare #(.PIX_W(PIX_W)) u_cmp (
    .pixel     (in_pixel),
    .row_odd   (pos_row),
    .col       (pos_col),
    .threshold (cur_threshold),
    .result    (bin_pixel)
  );

  dith_outstage #(.PIX_W(PIX_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (bin_pixel),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_pixel)
  );
endmodule

// File: rtl/dith_checker.sv
module dith_checker
  import dith_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             in_sol,
  input logic             in_sof,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pixel,
  input logic             pos_row,
  input logic [COL_W-1:0] pos_col
);
  logic last_row;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_row <= 1'b0;
      seen     <= 1'b0;
    end else if (accept) begin
      last_row <= pos_row;
      seen     <= 1'b1;
    end
  end

  assert_binary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pixel == '0 || out_pixel == {PIX_W{1'b1}}));

  assert_line_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_sol |-> pos_col == '0);

  assert_frame_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_sof |-> (pos_row == 1'b0 && pos_col == '0));

  assert_row_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_sol && !in_sof && seen |-> pos_row != last_row);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel));
endmodule

bind dither_thresholder dith_checker #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .in_sol    (in_sol),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .pos_row   (pos_row),
  .pos_col   (pos_col)
);

// File: tb/tb_dither_thresholder.sv
module tb_dither_thresholder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pixel = 8'd0;
  logic       in_sol = 1'b0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_pixel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dither_thresholder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_sol(in_sol), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  int    exp_q[$];
  string tag_q[$];
  int    m_row = 0;
  int    m_next = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Even-row pattern in eighths: 1,5,7,3; odd rows are offset by two slots.
  function automatic int bench_thr(input int row, input int col);
    int e[4] = '{1, 5, 7, 3};
    return (e[(col + 2 * row) % 4] * 256) / 8;
  endfunction

  bit stall_prev = 1'b0;
  int stall_pix  = 0;
  bit acc_prev   = 1'b0;

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (stall_prev) check(out_valid && out_pixel == stall_pix, "R8 hold", out_pixel, stall_pix);
      if (acc_prev) check(out_valid, "R7 latency", out_valid, 1);
      if (out_ready) check(in_ready, "R7 ready with out_ready", in_ready, 1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8 extra output", out_pixel, -1);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_pixel == e, t, out_pixel, e);
        end
      end
      if (in_valid && in_ready) begin
        int r, c, th;
        if (in_sof) begin r = 0; c = 0; end
        else if (in_sol) begin r = 1 - m_row; c = 0; end
        else begin r = m_row; c = m_next; end
        th = bench_thr(r, c);
        m_row = r;
        m_next = (c + 1) % 4;
        exp_q.push_back(int'(in_pixel) > th ? 255 : 0);
        if (int'(in_pixel) == th) tag_q.push_back("R3 equal");
        else if (r == 1) tag_q.push_back("R2 odd row R4 R5");
        else tag_q.push_back("R1 even row R4 R5");
      end
      stall_prev = out_valid && !out_ready;
      stall_pix  = out_pixel;
      acc_prev   = in_valid && in_ready;
    end
  end

  task automatic drive(input bit v, input int pix, input bit sol, input bit sof, input bit rdy);
    @(negedge clk);
    in_valid  = v;
    in_pixel  = 8'(pix);
    in_sol    = sol;
    in_sof    = sof;
    out_ready = rdy;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R6 reset in_ready", in_ready, 1);
    // R6: unmarked first pixel on even row phase 0; R3 equality cases
    drive(1, 32, 0, 0, 1);
    drive(1, 161, 0, 0, 1);
    drive(1, 224, 0, 0, 1);
    drive(1, 97, 0, 0, 1);
    drive(1, 33, 0, 0, 1);  // R4 wrap to phase 0
    drive(1, 225, 1, 0, 1); // R5 odd row, threshold 224
    drive(0, 0, 1, 1, 1);   // R9 markers with no valid
    drive(1, 96, 0, 0, 1);  // odd phase 1, equal -> 0
    drive(1, 33, 0, 0, 1);  // odd phase 2, threshold 32
    drive(1, 160, 0, 0, 0); // R8 stall
    drive(1, 160, 0, 0, 0);
    drive(1, 160, 0, 0, 1);
    drive(1, 200, 0, 1, 1); // R5 frame restart
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = (($urandom % 4) == 0) ? bench_thr($urandom % 2, $urandom % 4) + int'($urandom % 3) - 1
                                : int'($urandom % 256);
      if (p < 0) p = 0;
      if (p > 255) p = 255;
      drive(($urandom % 4) != 0, p, ($urandom % 7) == 0, ($urandom % 31) == 0,
            ($urandom % 3) != 0);
    end
    drive(0, 0, 0, 0, 1);
    repeat (4) drive(0, 0, 0, 0, 1);
    #3;
    check(exp_q.size() == 0, "R8 no lost pixels", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule